// File: doc/BRIEF.md
# Link Error Interrupt Status Controller

This block collects six single-cycle error event pulses from a serial link controller into a sticky status register. Software sees that status in two ways: as a raw view that records every event, and as a masked view limited to the sources it has enabled. Software clears status bits by writing ones to either view. The enable mask changes only through two write-only-style ports: a set register and a clear register, each acting on the bits written as one.

The block drives one combined error interrupt, which is the OR of the masked status. It also drives a separate fatal indication, raised when either of the two fatal-class sources is pending and enabled. The error detectors themselves sit outside the block. Register access is a plain 32-bit word interface with a combinational read path.

Top module: `link_err_irq_ctrl`

## Requirements
- R1: After a synchronous reset, the raw status, masked status and enable mask all read 0, and both `err_irq_o` and `fatal_o` are low.
- R2: A pulse on `evt_i[k]` sets raw status bit k at the next clock edge, whatever the enable mask holds. The bit stays set until software clears it. Bit positions: 0 system error, 1 fatal, 2 non-fatal, 3 correctable, 4 bus tag-lookup fatal, 5 end-to-end CRC error.
- R3: The raw status reads at offset 0x1C0. The masked status reads at offset 0x1C4 and equals raw AND enable.
- R4: Writing to offset 0x1C8 sets the enable bits written as 1. Writing to offset 0x1CC clears the enable bits written as 1. Zero bits leave the mask unchanged, and reading either offset returns the enable mask. Writing 0x3F to 0x1C8 enables all six sources.
- R5: Writing to 0x1C0 or 0x1C4 clears the status bits written as 1 and leaves the bits written as 0 unchanged.
- R6: When an event arrives in the same cycle as a write-one-to-clear of its bit, the bit stays set.
- R7: `err_irq_o` is high exactly when any masked status bit is set, including when a source is enabled after its event has already been recorded.
- R8: `fatal_o` is high exactly when masked status bit 1 or bit 4 is set.
- R9: Read-data bits 31 to 6 are always 0, and writes to those bits have no effect. Offsets outside the four registers read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| evt_i | input | 6 | Error event pulses, one per source |
| err_irq_o | output | 1 | Combined error interrupt |
| fatal_o | output | 1 | Fatal-class error pending and enabled |

## Verification
Two functions can land in the same cycle: a new event on a source, and a write-one-to-clear of that source's status bit. The bench first sets the status bits, then in one cycle drives an all-ones clear write together with event pulses on a chosen subset of sources. It then reads the raw view back and expects exactly that subset to remain. A sweep over all 64 event patterns against several enable masks then judges the raw view, the masked view and both interrupt outputs against arithmetic expectations.

// File: rtl/link_err_pkg.sv
package link_err_pkg;

    localparam int ERR_W     = 6;
    localparam int REG_AW    = 12;
    localparam int REG_DW    = 32;

    localparam logic [REG_AW-1:0] OFS_RAW    = 12'h1C0;
    localparam logic [REG_AW-1:0] OFS_MASKED = 12'h1C4;
    localparam logic [REG_AW-1:0] OFS_EN_SET = 12'h1C8;
    localparam logic [REG_AW-1:0] OFS_EN_CLR = 12'h1CC;

    // bits 1 (fatal) and 4 (bus tag-lookup fatal)
    localparam logic [ERR_W-1:0] FATAL_CLASS = 6'b01_0010;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_RAW,
        SEL_MASKED,
        SEL_EN_SET,
        SEL_EN_CLR
    } reg_sel_e;

    typedef struct packed {
        logic             clr_stat;
        logic             en_set;
        logic             en_clr;
        logic [ERR_W-1:0] bits;
    } wr_cmd_t;

    function automatic logic sel_is_status(input reg_sel_e s);
        return (s == SEL_RAW) || (s == SEL_MASKED);
    endfunction

    function automatic logic sel_is_enable(input reg_sel_e s);
        return (s == SEL_EN_SET) || (s == SEL_EN_CLR);
    endfunction

endpackage

// File: rtl/link_err_decode.sv
module link_err_decode
    import link_err_pkg::*;
#(
    parameter int                ADDR_W  = REG_AW,
    parameter int                DATA_W  = REG_DW,
    parameter int                NUM_SRC = ERR_W,
    parameter logic [ADDR_W-1:0] A_RAW   = OFS_RAW,
    parameter logic [ADDR_W-1:0] A_MSK   = OFS_MASKED,
    parameter logic [ADDR_W-1:0] A_ESET  = OFS_EN_SET,
    parameter logic [ADDR_W-1:0] A_ECLR  = OFS_EN_CLR
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output reg_sel_e          sel,
    output wr_cmd_t           cmd
);

    always_comb begin
        unique case (addr)
            A_RAW:   sel = SEL_RAW;
            A_MSK:   sel = SEL_MASKED;
            A_ESET:  sel = SEL_EN_SET;
            A_ECLR:  sel = SEL_EN_CLR;
            default: sel = SEL_NONE;
        endcase
    end

    always_comb begin
        cmd          = '0;
        cmd.bits     = wdata[NUM_SRC-1:0];
        cmd.clr_stat = wr_en && sel_is_status(sel);
        cmd.en_set   = wr_en && (sel == SEL_EN_SET);
        cmd.en_clr   = wr_en && (sel == SEL_EN_CLR);
    end

endmodule

// File: rtl/link_err_status.sv
module link_err_status #(
    parameter int NUM_SRC = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] evt,
    input  logic [NUM_SRC-1:0] clr_mask,
    output logic [NUM_SRC-1:0] raw_q
);

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                raw_q[k] <= 1'b0;
            else if (evt[k])
                raw_q[k] <= 1'b1;      // new event beats a same-cycle clear
            else if (clr_mask[k])
                raw_q[k] <= 1'b0;
        end
    end

endmodule

// File: rtl/link_err_enable.sv
module link_err_enable #(
    parameter int NUM_SRC = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] set_mask,
    input  logic [NUM_SRC-1:0] clr_mask,
    output logic [NUM_SRC-1:0] en_q
);

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= '0;
        else
            en_q <= (en_q | set_mask) & ~clr_mask;
    end

endmodule

// File: rtl/link_err_irq_ctrl.sv
module link_err_irq_ctrl
    import link_err_pkg::*;
#(
    parameter int                 ADDR_W     = REG_AW,
    parameter int                 DATA_W     = REG_DW,
    parameter int                 NUM_SRC    = ERR_W,
    parameter logic [NUM_SRC-1:0] FATAL_MASK = FATAL_CLASS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    input  logic [NUM_SRC-1:0] evt_i,
    output logic               err_irq_o,
    output logic               fatal_o
);

    localparam int PAD_W = DATA_W - NUM_SRC;

    reg_sel_e           sel;
    wr_cmd_t            cmd;
    logic [NUM_SRC-1:0] raw_q;
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] masked;
    logic [NUM_SRC-1:0] stat_clr;
    logic [NUM_SRC-1:0] en_set;
    logic [NUM_SRC-1:0] en_clr;
    logic [NUM_SRC-1:0] view;

    link_err_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .NUM_SRC(NUM_SRC)
    ) u_decode (
        .wr_en(wr_en),
        .addr (addr),
        .wdata(wdata),
        .sel  (sel),
        .cmd  (cmd)
    );

    assign stat_clr = cmd.clr_stat ? cmd.bits : '0;
    assign en_set   = cmd.en_set   ? cmd.bits : '0;
    assign en_clr   = cmd.en_clr   ? cmd.bits : '0;

    link_err_status #(.NUM_SRC(NUM_SRC)) u_status (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt_i),
        .clr_mask(stat_clr),
        .raw_q   (raw_q)
    );

    link_err_enable #(.NUM_SRC(NUM_SRC)) u_enable (
        .clk     (clk),
        .rst     (rst),
        .set_mask(en_set),
        .clr_mask(en_clr),
        .en_q    (en_q)
    );

    assign masked    = raw_q & en_q;
    assign err_irq_o = |masked;
    assign fatal_o   = |(masked & FATAL_MASK);

    always_comb begin
        unique case (sel)
            SEL_RAW:    view = raw_q;
            SEL_MASKED: view = masked;
            SEL_EN_SET,
            SEL_EN_CLR: view = en_q;
            default:    view = '0;
        endcase
    end

    assign rdata = {{PAD_W{1'b0}}, view};

endmodule

// File: rtl/link_err_irq_chk.sv
module link_err_irq_chk #(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter int NUM_SRC = 6
) (
    input logic               clk,
    input logic               rst,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  addr,
    input logic [DATA_W-1:0]  wdata,
    input logic [DATA_W-1:0]  rdata,
    input logic [NUM_SRC-1:0] evt_i,
    input logic               err_irq_o,
    input logic               fatal_o,
    input logic [NUM_SRC-1:0] raw_q,
    input logic [NUM_SRC-1:0] en_q
);

    logic stat_wr;
    assign stat_wr = wr_en && ((addr == 12'h1C0) || (addr == 12'h1C4));

    // R2 / R6: every pulsed source is recorded, even under a clear write
    assert_evt_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        (|evt_i) |=> ((raw_q & $past(evt_i)) == $past(evt_i)));

    // R5: clear write removes the bits written as 1 that had no new event
    assert_w1c_R5: assert property (@(posedge clk) disable iff (rst)
        stat_wr |=> ((raw_q & $past(wdata[NUM_SRC-1:0] & ~evt_i)) == '0));

    // R2: without a status write nothing already set goes away
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !stat_wr |=> ((raw_q & $past(raw_q)) == $past(raw_q)));

    // R8: a fatal indication implies the combined interrupt
    assert_fatal_in_irq_R8: assert property (@(posedge clk) disable iff (rst)
        fatal_o |-> err_irq_o);

    // R7: interrupt tracks enabled pending sources
    assert_irq_R7: assert property (@(posedge clk) disable iff (rst)
        err_irq_o == ((raw_q & en_q) != '0));

    // R9: upper read-data bits stay zero
    assert_upper_zero_R9: assert property (@(posedge clk) disable iff (rst)
        rdata[DATA_W-1:NUM_SRC] == '0);

    // R4: enable changes only through a write to the set or clear offset
    assert_en_stable_R4: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && ((addr == 12'h1C8) || (addr == 12'h1CC))) |=> $stable(en_q));

endmodule

bind link_err_irq_ctrl link_err_irq_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .NUM_SRC(NUM_SRC)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .evt_i    (evt_i),
    .err_irq_o(err_irq_o),
    .fatal_o  (fatal_o),
    .raw_q    (raw_q),
    .en_q     (en_q)
);

// File: tb/link_err_irq_ctrl_tb_top.sv
module link_err_irq_ctrl_tb_top;

    localparam logic [11:0] A_RAW  = 12'h1C0;
    localparam logic [11:0] A_MSK  = 12'h1C4;
    localparam logic [11:0] A_ESET = 12'h1C8;
    localparam logic [11:0] A_ECLR = 12'h1CC;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [5:0]  evt = '0;
    logic        err_irq;
    logic        fatal;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    link_err_irq_ctrl dut_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .evt_i    (evt),
        .err_irq_o(err_irq),
        .fatal_o  (fatal)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // drive at falling edge, takes effect at the next rising edge
    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [5:0] e = '0);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d; evt = e;
        @(negedge clk);
        wr_en = 1'b0; evt = '0;
    endtask

    task automatic pulse(input logic [5:0] e);
        @(negedge clk);
        evt = e;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wipe();
        wr(A_ECLR, 32'h3F);
        wr(A_RAW, 32'h3F);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(A_RAW, r);  check("R1 raw", r, 0);
        rd(A_MSK, r);  check("R1 masked", r, 0);
        rd(A_ESET, r); check("R1 enable", r, 0);
        check("R1 irq", {31'b0, err_irq}, 0);
        check("R1 fatal", {31'b0, fatal}, 0);

        // R2/R3/R7/R8 sweep: every event pattern under several masks
        for (int m = 0; m < 4; m++) begin
            logic [5:0] en;
            case (m)
                0: en = 6'h00;
                1: en = 6'h3F;
                2: en = 6'h12;
                default: en = 6'h2D;
            endcase
            for (int e = 0; e < 64; e++) begin
                logic [5:0] msk;
                wipe();
                wr(A_ESET, {26'b0, en});
                pulse(e[5:0]);
                msk = e[5:0] & en;
                rd(A_RAW, r);  check("R2 raw sweep", r, {26'b0, e[5:0]});
                rd(A_MSK, r);  check("R3 masked sweep", r, {26'b0, msk});
                rd(A_ECLR, r); check("R4 enable readback", r, {26'b0, en});
                check("R7 irq sweep", {31'b0, err_irq}, {31'b0, msk != 0});
                check("R8 fatal sweep", {31'b0, fatal}, {31'b0, (msk & 6'h12) != 0});
            end
        end

        // R2 stickiness across idle cycles
        wipe();
        pulse(6'h08);
        repeat (10) @(negedge clk);
        rd(A_RAW, r); check("R2 sticky", r, 32'h08);

        // R7 late enable of a recorded source raises irq
        check("R7 irq while disabled", {31'b0, err_irq}, 0);
        wr(A_ESET, 32'h08);
        check("R7 irq after enable", {31'b0, err_irq}, 1);
        check("R8 non-fatal source", {31'b0, fatal}, 0);

        // R4 set and clear act on one-bits only
        wr(A_ESET, 32'h3F);
        wr(A_ECLR, 32'h21);
        rd(A_ESET, r); check("R4 enable clear", r, 32'h1E);
        wr(A_ESET, 32'h00);
        rd(A_ESET, r); check("R4 zero set no effect", r, 32'h1E);

        // R5 partial clear through the masked offset
        wipe();
        wr(A_ESET, 32'h3F);
        pulse(6'h3F);
        wr(A_MSK, 32'h15);
        rd(A_RAW, r); check("R5 partial clear", r, 32'h2A);
        wr(A_RAW, 32'h0A);
        rd(A_RAW, r); check("R5 clear via raw", r, 32'h20);

        // R6 event collides with clear of same bit
        wipe();
        pulse(6'h3F);
        wr(A_RAW, 32'h3F, 6'h05);
        rd(A_RAW, r); check("R6 event wins", r, 32'h05);

        // R9 upper bits and unmapped offsets
        wipe();
        wr(A_ESET, 32'hFFFF_FFC0);
        rd(A_ESET, r); check("R9 upper set ignored", r, 0);
        wr(12'h1D0, 32'hFFFF_FFFF);
        rd(A_ESET, r); check("R9 unmapped write ignored", r, 0);
        pulse(6'h10);
        wr(12'h1BC, 32'hFFFF_FFFF);
        rd(A_RAW, r); check("R9 unmapped write no clear", r, 32'h10);
        rd(12'h1D0, r); check("R9 unmapped read", r, 0);
        wr(A_RAW, 32'hFFFF_FFC0);
        rd(A_RAW, r); check("R9 upper clear ignored", r, 32'h10);

        // R1 reset clears everything
        wr(A_ESET, 32'h3F);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd(A_RAW, r);  check("R1 raw after reset", r, 0);
        rd(A_ESET, r); check("R1 enable after reset", r, 0);
        check("R1 irq after reset", {31'b0, err_irq}, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule